// File: doc/BRIEF.md
# Masked Vector Broadcast Unit

This block builds a destination vector of up to 512 bits by repeating a source pattern across it. The pattern is either one source element of 8, 16, 32 or 64 bits, or a short run of consecutive 32-bit or 64-bit source elements. Destination element j takes source element (j mod G), where G is the number of elements in the pattern. A per-element write mask can then choose which destination elements take the new value. An element that is not written either keeps its prior value (merge) or is cleared (zero). Everything above the selected vector length is cleared.

The caller presents the source word, the previous destination value and the control fields, and pulses a strobe. One clock later the new destination appears with a valid pulse. A combination of element size, pattern length and vector length that is not supported raises an illegal flag instead of the valid pulse, and the stored destination stays as it was.

Top module: `vbcast_unit`

## Requirements
- R1: Element size code esize 0,1,2,3 selects 8,16,32,64-bit elements. Vector length code vlen 0,1,2 selects 128,256,512 bits. With group code 0 (one element), every active element equals source bits [E-1:0], where E is the element width.
- R2: Group code grp 0,1,2,3 selects patterns of 1,2,4,8 elements. Destination element j equals source element (j mod G).
- R3: When mask_en is 0, every active element is written regardless of the mask.
- R4: When mask_en is 1, zero_mode is 0 and mask bit j is 0, element j keeps its value from prev.
- R5: When mask_en is 1, zero_mode is 1 and mask bit j is 0, element j becomes zero.
- R6: All destination bits at or above the active vector length are zero, whatever the mask and mode.
- R7: Four 32-bit elements at 256 bits with masking off place source bits [127:0] in both the low and the high 128-bit halves, and bits 511:256 are zero.
- R8: The following combinations are illegal: vlen 3; grp other than 0 with esize below 2; and any group whose total width times two exceeds the vector length. The last rule makes 4x32 and 2x64 need at least 256 bits, makes 8x32 and 4x64 need 512 bits, and rules out 8x64. A strobe with an illegal combination raises illegal one cycle later.
- R9: An illegal strobe does not pulse out_vld and leaves dest unchanged.
- R10: Mask bits at or above the active element count have no effect on dest.
- R11: dest and out_vld update on the clock edge that samples in_vld. out_vld is a single-cycle pulse, and dest holds between strobes.
- R12: An active-low reset clears dest, out_vld and illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_vld | input | 1 | Input strobe |
| src | input | 256 | Source elements |
| esize | input | 2 | Element size code |
| grp | input | 2 | Group length code |
| vlen | input | 2 | Vector length code |
| mask | input | 64 | Per-element write mask |
| mask_en | input | 1 | Enables the write mask |
| zero_mode | input | 1 | 1 clears masked-off elements, 0 merges |
| prev | input | 512 | Previous destination value |
| dest | output | 512 | Registered destination |
| out_vld | output | 1 | Result valid pulse |
| illegal | output | 1 | Unsupported combination pulse |

## Verification
Each problem shows at the ports in the cycle right after the strobe, because the output is a single register stage:
- A wrong pattern index shows up as misplaced bytes in dest.
- A wrong element-to-mask mapping shows up as the wrong elements being merged or cleared.
- A wrong length limit leaves nonzero bits above the active vector length.
- A wrong legality decision swaps the out_vld pulse for an illegal pulse, or the reverse.
- A broken clock enable changes dest during idle cycles or after an illegal strobe.

Reference results are computed bit by bit per element, so any of these faults shows as a mismatch on that first result.

// File: rtl/vbcast_pkg.sv
`timescale 1ns/1ps
package vbcast_pkg;
  localparam int unsigned DST_BITS = 512;
  localparam int unsigned SRC_BITS = 256;

  typedef enum logic [1:0] {ES_B8, ES_B16, ES_B32, ES_B64} esize_e;
  typedef enum logic [1:0] {GP_1, GP_2, GP_4, GP_8} group_e;
  typedef enum logic [1:0] {VL_128, VL_256, VL_512, VL_RSVD} vlen_e;
endpackage

// File: rtl/vbcast_legal.sv
`timescale 1ns/1ps
module vbcast_legal
  import vbcast_pkg::*;
(
  input  logic [1:0] esize,
  input  logic [1:0] grp,
  input  logic [1:0] vlen,
  output logic [2:0] span_lg,
  output logic       bad
);
  // span_lg: log2 of the pattern width in bytes
  logic [2:0] vec_lim;
  logic       rsvd_len;
  logic       narrow_grp;
  logic       too_wide;

  always_comb begin
    span_lg    = {1'b0, esize} + {1'b0, grp};
    vec_lim    = {1'b0, vlen} + 3'd3;
    rsvd_len   = (vlen == VL_RSVD);
    narrow_grp = (grp != GP_1) && (esize < ES_B32);
    // pattern bits * 2 must not exceed vector bits
    too_wide   = (span_lg > vec_lim);
    bad        = rsvd_len | narrow_grp | too_wide;
  end
endmodule

// File: rtl/vbcast_replicate.sv
`timescale 1ns/1ps
module vbcast_replicate #(
  parameter int unsigned DST_BYTES = 64,
  parameter int unsigned SRC_BYTES = 32
) (
  input  logic [SRC_BYTES*8-1:0] src,
  input  logic [2:0]             span_lg,
  output logic [DST_BYTES*8-1:0] pat
);
  localparam int unsigned IDX_W = $clog2(SRC_BYTES);

  logic [IDX_W-1:0] wrap;

  always_comb begin
    wrap = IDX_W'((32'd1 << span_lg) - 32'd1);
  end

  for (genvar b = 0; b < DST_BYTES; b++) begin : g_byte
    localparam logic [IDX_W-1:0] BLO = IDX_W'(b % SRC_BYTES);
    logic [IDX_W-1:0] sel;
    always_comb begin
      sel = BLO & wrap;
      pat[b*8 +: 8] = src[sel*8 +: 8];
    end
  end
endmodule

// File: rtl/vbcast_mask.sv
`timescale 1ns/1ps
module vbcast_mask #(
  parameter int unsigned DST_BYTES = 64
) (
  input  logic [DST_BYTES*8-1:0] pat,
  input  logic [DST_BYTES*8-1:0] prev,
  input  logic [DST_BYTES-1:0]   mask,
  input  logic [1:0]             esize,
  input  logic [1:0]             vlen,
  input  logic                   mask_en,
  input  logic                   zero_mode,
  output logic [DST_BYTES*8-1:0] res
);
  localparam int unsigned EI_W = $clog2(DST_BYTES);

  logic [7:0] byte_lim;

  always_comb begin
    byte_lim = 8'd16 << vlen;
  end

  for (genvar b = 0; b < DST_BYTES; b++) begin : g_lane
    localparam logic [EI_W-1:0] BI = EI_W'(b);
    logic [EI_W-1:0] eidx;
    logic            live;
    logic            wr;
    always_comb begin
      eidx = BI >> esize;
      live = (8'(b) < byte_lim);
      wr   = !mask_en || mask[eidx];
      if (!live)
        res[b*8 +: 8] = 8'h00;
      else if (wr)
        res[b*8 +: 8] = pat[b*8 +: 8];
      else if (zero_mode)
        res[b*8 +: 8] = 8'h00;
      else
        res[b*8 +: 8] = prev[b*8 +: 8];
    end
  end
endmodule

// File: rtl/vbcast_unit.sv
`timescale 1ns/1ps
module vbcast_unit
  import vbcast_pkg::*;
#(
  parameter int unsigned DST_W = DST_BITS,
  parameter int unsigned SRC_W = SRC_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [SRC_W-1:0] src,
  input  logic [1:0]       esize,
  input  logic [1:0]       grp,
  input  logic [1:0]       vlen,
  input  logic [DST_W/8-1:0] mask,
  input  logic             mask_en,
  input  logic             zero_mode,
  input  logic [DST_W-1:0] prev,
  output logic [DST_W-1:0] dest,
  output logic             out_vld,
  output logic             illegal
);
  localparam int unsigned DBYTES = DST_W / 8;
  localparam int unsigned SBYTES = SRC_W / 8;

  logic [2:0]       span_lg;
  logic             bad;
  logic [DST_W-1:0] pat;
  logic [DST_W-1:0] res;

  logic [DST_W-1:0] dest_q;
  logic             vld_q, ill_q;
  logic             vld_d, ill_d, dest_en;

  vbcast_legal u_legal (
    .esize   (esize),
    .grp     (grp),
    .vlen    (vlen),
    .span_lg (span_lg),
    .bad     (bad)
  );

  vbcast_replicate #(.DST_BYTES(DBYTES), .SRC_BYTES(SBYTES)) u_rep (
    .src     (src),
    .span_lg (span_lg),
    .pat     (pat)
  );

  vbcast_mask #(.DST_BYTES(DBYTES)) u_msk (
    .pat       (pat),
    .prev      (prev),
    .mask      (mask),
    .esize     (esize),
    .vlen      (vlen),
    .mask_en   (mask_en),
    .zero_mode (zero_mode),
    .res       (res)
  );

  // next state
  always_comb begin
    dest_en = in_vld && !bad;
    vld_d   = in_vld && !bad;
    ill_d   = in_vld && bad;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      ill_q <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dest_q <= '0;
    else if (dest_en)
      dest_q <= res;
  end

  assign dest    = dest_q;
  assign out_vld = vld_q;
  assign illegal = ill_q;
endmodule

// File: rtl/vbcast_chk.sv
`timescale 1ns/1ps
module vbcast_chk #(
  parameter int unsigned DST_W = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld,
  input logic [1:0]       esize,
  input logic [1:0]       grp,
  input logic [1:0]       vlen,
  input logic [DST_W/8-1:0] mask,
  input logic             mask_en,
  input logic             zero_mode,
  input logic [DST_W-1:0] dest,
  input logic             out_vld,
  input logic             illegal
);
  // R9: never both pulses
  p_one_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_vld, illegal}));

  // R9: illegal strobe leaves dest untouched
  p_hold_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $stable(dest));

  // R11: valid only after a strobe
  p_vld_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld || illegal) |-> $past(in_vld));

  // R11: idle cycles hold dest
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> $stable(dest));

  // R6: bits above a 128-bit vector are clear
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(vlen) == 2'd0) |-> (dest[DST_W-1:128] == '0));

  // R5: zeroing with an empty mask clears everything
  p_zero_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(mask_en) && $past(zero_mode) && $past(mask) == '0)
      |-> (dest == '0));

  // R1: unmasked byte broadcast at full length: first and last bytes equal
  p_byte_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(esize) == 2'd0 && $past(grp) == 2'd0 &&
     !$past(mask_en) && $past(vlen) == 2'd2)
      |-> (dest[7:0] == dest[DST_W-1:DST_W-8]));
endmodule

bind vbcast_unit vbcast_chk #(.DST_W(DST_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_vld    (in_vld),
  .esize     (esize),
  .grp       (grp),
  .vlen      (vlen),
  .mask      (mask),
  .mask_en   (mask_en),
  .zero_mode (zero_mode),
  .dest      (dest),
  .out_vld   (out_vld),
  .illegal   (illegal)
);

// File: tb/sim_vbcast_unit.sv
`timescale 1ns/1ps
module sim_vbcast_unit;
  logic         clk;
  logic         rst_n;
  logic         in_vld;
  logic [255:0] src;
  logic [1:0]   esize, grp, vlen;
  logic [63:0]  mask;
  logic         mask_en, zero_mode;
  logic [511:0] prev;
  logic [511:0] dest;
  logic         out_vld, illegal;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  vbcast_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .src(src),
    .esize(esize), .grp(grp), .vlen(vlen), .mask(mask),
    .mask_en(mask_en), .zero_mode(zero_mode), .prev(prev),
    .dest(dest), .out_vld(out_vld), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {esize, grp, vlen, mask_en, zero_mode, mask, expect_illegal}
  localparam int NV = 19;
  localparam logic [72:0] TBL [0:NV-1] = '{
    {2'd0, 2'd0, 2'd2, 1'b0, 1'b0, 64'h0, 1'b0},                   // R1 bytes 512
    {2'd1, 2'd0, 2'd1, 1'b0, 1'b0, 64'h0, 1'b0},                   // R1 halves 256
    {2'd2, 2'd0, 2'd0, 1'b0, 1'b0, 64'h0, 1'b0},                   // R1 R6 words 128
    {2'd3, 2'd0, 2'd2, 1'b1, 1'b0, 64'hA5, 1'b0},                  // R4 merge
    {2'd2, 2'd1, 2'd0, 1'b0, 1'b0, 64'h0, 1'b0},                   // R2 2x32 128
    {2'd2, 2'd2, 2'd1, 1'b0, 1'b0, 64'h0, 1'b0},                   // R7 4x32 256
    {2'd2, 2'd3, 2'd2, 1'b1, 1'b1, 64'hF0F3, 1'b0},                // R2 R5 8x32 zero
    {2'd3, 2'd1, 2'd1, 1'b1, 1'b0, 64'h5, 1'b0},                   // R2 R4 2x64
    {2'd3, 2'd2, 2'd2, 1'b0, 1'b0, 64'h0, 1'b0},                   // R2 4x64 512
    {2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_0F0F, 1'b0}, // R10 bytes 128
    {2'd1, 2'd0, 2'd2, 1'b1, 1'b1, 64'hFFFF_FFFF_8000_0001, 1'b0}, // R10 halves 512
    {2'd2, 2'd2, 2'd0, 1'b0, 1'b0, 64'h0, 1'b1},                   // R8 4x32 at 128
    {2'd3, 2'd3, 2'd2, 1'b0, 1'b0, 64'h0, 1'b1},                   // R8 8x64
    {2'd0, 2'd1, 2'd2, 1'b0, 1'b0, 64'h0, 1'b1},                   // R8 2x8
    {2'd2, 2'd0, 2'd3, 1'b0, 1'b0, 64'h0, 1'b1},                   // R8 reserved length
    {2'd3, 2'd2, 2'd1, 1'b0, 1'b0, 64'h0, 1'b1},                   // R8 4x64 at 256
    {2'd2, 2'd3, 2'd1, 1'b0, 1'b0, 64'h0, 1'b1},                   // R8 8x32 at 256
    {2'd3, 2'd1, 2'd0, 1'b0, 1'b0, 64'h0, 1'b1},                   // R8 2x64 at 128
    {2'd1, 2'd0, 2'd0, 1'b1, 1'b1, 64'h0, 1'b0}                    // R5 all cleared
  };

  function automatic logic [511:0] ref_dest(
    input logic [255:0] s, input logic [511:0] p,
    input int es, input int g, input int vl,
    input logic men, input logic zm, input logic [63:0] m);
    logic [511:0] r;
    int ebits, vbits, gsz, j, k;
    ebits = 8 << es;
    vbits = 128 << vl;
    gsz   = 1 << g;
    for (int q = 0; q < 512; q++) begin
      j = q / ebits;
      k = q % ebits;
      if (q >= vbits)          r[q] = 1'b0;
      else if (!men || m[j])   r[q] = s[(j % gsz) * ebits + k];
      else if (zm)             r[q] = 1'b0;
      else                     r[q] = p[q];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [511:0] last, exp_d;
    logic [72:0]  e;
    logic [255:0] base;
    rst_n = 1'b0; in_vld = 1'b0; esize = '0; grp = '0; vlen = '0;
    mask = '0; mask_en = 1'b0; zero_mode = 1'b0; src = '0; prev = '0;
    for (int i = 0; i < 32; i++) base[i*8 +: 8] = 8'(i * 37 + 11);
    for (int i = 0; i < 64; i++) prev[i*8 +: 8] = ~8'(i * 13);
    repeat (3) @(negedge clk);
    check(dest == '0 && !out_vld && !illegal, "R12 reset",
          {509'd0, out_vld, illegal, |dest}, '0);
    rst_n = 1'b1;
    last = '0;

    for (int i = 0; i < NV; i++) begin
      e = TBL[i];
      @(negedge clk);
      src = base ^ {32{8'(i * 29)}};
      esize = e[72:71]; grp = e[70:69]; vlen = e[68:67];
      mask_en = e[66]; zero_mode = e[65]; mask = e[64:1];
      in_vld = 1'b1;
      @(negedge clk);
      in_vld = 1'b0;
      if (e[0]) begin
        check(illegal && !out_vld, "R8 R9 illegal flag",
              {510'd0, out_vld, illegal}, 512'd1);
        check(dest == last, "R9 dest held", dest, last);
      end else begin
        exp_d = ref_dest(src, prev, int'(e[72:71]), int'(e[70:69]),
                         int'(e[68:67]), e[66], e[65], e[64:1]);
        check(out_vld && !illegal, "R11 valid pulse",
              {510'd0, out_vld, illegal}, 512'd2);
        check(dest == exp_d, "R1 R2 R3 R4 R5 R6 R10 data", dest, exp_d);
        last = exp_d;
      end
    end

    // R7: explicit halves check for the 128-bit group at 256
    @(negedge clk);
    src = base; esize = 2'd2; grp = 2'd2; vlen = 2'd1; mask_en = 1'b0;
    in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    exp_d = {256'd0, base[127:0], base[127:0]};
    check(dest == exp_d, "R7 halves", dest, exp_d);

    // R3: mask ignored when masking disabled
    @(negedge clk);
    src = base; esize = 2'd2; grp = 2'd0; vlen = 2'd2;
    mask = 64'h0; mask_en = 1'b0; zero_mode = 1'b1; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    exp_d = {16{base[31:0]}};
    check(dest == exp_d, "R3 mask off", dest, exp_d);
    last = exp_d;

    // R11: no strobe, inputs changed, dest holds and no pulse
    src = ~base; mask_en = 1'b1; mask = '0;
    repeat (2) @(negedge clk);
    check(dest == last && !out_vld, "R11 hold", dest, last);

    // R12: reset mid-run
    rst_n = 1'b0;
    #1;
    check(dest == '0 && !out_vld && !illegal, "R12 mid reset", dest, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule